// File: doc/BRIEF.md
# Four-Lane Striped Vector Adder

This block adds two vectors of 32-bit integers element by element and writes the sum into a third vector register. It holds eight vector registers of up to sixteen elements each. An instruction names a destination register, two source registers and a vector length. The elements are split across four parallel adder lanes, with element i handled by lane i mod 4. The four elements 4k to 4k+3 form one element group. A group enters the lanes in one cycle and moves through the two-stage adder pipelines as a unit. One cycle after it leaves the last stage, each live lane writes its element into the destination register.

Instructions arrive on a valid/ready issue port, and the rules of that port are as follows. An instruction is taken on a clock edge where both `iss_valid` and `iss_ready` are high. While `iss_valid` is high and `iss_ready` is low, the sender must hold all issue fields steady. The block lowers `iss_ready` while it is still stepping the groups of the current instruction. It also lowers it while the offered instruction reads or writes a register that an in-flight instruction has yet to write. If the next instruction is independent of the in-flight ones, `iss_ready` is high during the issue cycle of the current instruction's final group. Its first group then follows in the very next cycle, while the earlier groups are still in the pipeline. A separate test port writes any element and reads any element back combinationally. A one-cycle `done` pulse, which carries the destination number, marks the write-back of each instruction's final group.

Top module: `vec_add_lanes`

## Requirements
- R1: For an accepted instruction of effective length n, destination element i equals source A element i plus source B element i, modulo 2^32, for every i < n. The source values used are those present when the instruction is accepted.
- R2: Element i is computed and written by lane i mod 4. The elements 4k to 4k+3 issue together in one cycle, so an instruction of effective length n takes max(1, ceil(n/4)) issue cycles.
- R3: An instruction accepted on clock edge e with G issue cycles raises `done` for exactly one cycle, starting after edge e+G+2. During that cycle `done_dst` shows its destination register number.
- R4: Destination elements at index n or above keep their previous values.
- R5: A length above 16 is treated as 16. A length of 0 writes no element but still produces its `done` pulse, one issue cycle after acceptance.
- R6: An instruction whose registers are disjoint from every in-flight destination is accepted on the edge that ends the previous instruction's last issue cycle, so the two acceptances are G cycles apart.
- R7: An instruction that reads or writes a register an in-flight instruction writes is held off until that instruction's final write-back. It is accepted on edge e+G+3 and sees the new values. When two instructions write the same register in turn, the later one's elements are the ones that remain.
- R8: Setting `tp_wr_en` writes `tp_wr_data` to element `tp_wr_idx` of register `tp_wr_reg` on the clock edge. `tp_rd_data` shows element `tp_rd_idx` of register `tp_rd_reg` with no delay.
- R9: After reset, `iss_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue fields are valid |
| iss_ready | output | 1 | Block accepts the issue fields this cycle |
| iss_dst | input | 3 | Destination register |
| iss_srca | input | 3 | First source register |
| iss_srcb | input | 3 | Second source register |
| iss_len | input | 5 | Vector length (0 to 31; values above 16 are treated as 16) |
| tp_wr_en | input | 1 | Test write strobe |
| tp_wr_reg | input | 3 | Test write register |
| tp_wr_idx | input | 4 | Test write element index |
| tp_wr_data | input | 32 | Test write value |
| tp_rd_reg | input | 3 | Test read register |
| tp_rd_idx | input | 4 | Test read element index |
| tp_rd_data | output | 32 | Test read value |
| done | output | 1 | Final group of an instruction written back |
| done_dst | output | 3 | Destination register of the finished instruction |

## Verification
The assertions check several behaviours on every cycle. A lane only ever writes element indices congruent to its own number. No lane writes outside a live group. The block is never ready in the middle of an instruction but is always ready when fully idle. Nothing is accepted while its registers collide with a write still in the pipeline. Other behaviours can only be shown by the bench's scenarios. These are the arithmetic results with wrap-around, the preserved tail elements, the clamping of long lengths, the exact done latency, the absence of a gap between independent instructions, the exact stall length of a dependent one, and the final contents after two writes to the same register.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int VLA_NREG = 8;
  localparam int VLA_RW   = $clog2(VLA_NREG);

  // control tag riding alongside one element group in the pipeline
  typedef struct packed {
    logic              vld;
    logic              last;
    logic [VLA_RW-1:0] dst;
  } vla_tag_t;
endpackage

// File: rtl/vla_lane.sv
module vla_lane #(
  parameter int EW    = 32,
  parameter int IW    = 4,
  parameter int LANES = 4,
  parameter int LANE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic [IW-1:0] in_idx,
  input  logic [EW-1:0] in_a,
  input  logic [EW-1:0] in_b,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [EW-1:0] wb_data
);
  logic          en1, en2;
  logic [IW-1:0] idx1, idx2;
  logic [EW-1:0] a1, b1, sum2;

  // stage 1: operand capture; stage 2: sum
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en1 <= 1'b0;
      en2 <= 1'b0;
    end else begin
      en1 <= in_en;
      en2 <= en1;
    end
    idx1 <= in_idx;
    a1   <= in_a;
    b1   <= in_b;
    idx2 <= idx1;
    sum2 <= a1 + b1;
  end

  assign wb_en   = en2;
  assign wb_idx  = idx2;
  assign wb_data = sum2;

  p_lane_stripe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ((int'(wb_idx) % LANES) == LANE))
    else $error("lane %0d wrote a foreign element", LANE);
endmodule

// File: rtl/vla_seq.sv
module vla_seq
  import vla_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAXVL = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int LW   = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [VLA_RW-1:0] iss_dst,
  input  logic [VLA_RW-1:0] iss_srca,
  input  logic [VLA_RW-1:0] iss_srcb,
  input  logic [LW-1:0]     iss_len,
  output logic [VLA_RW-1:0] rd_sa,
  output logic [VLA_RW-1:0] rd_sb,
  output logic [IW-1:0]     base,
  output logic [LANES-1:0]  lane_en,
  output vla_tag_t          t2
);
  logic              busy, last, hazard, accept;
  logic [VLA_RW-1:0] dst_r;
  logic [LW-1:0]     len_r, len_eff;
  vla_tag_t          t1;

  assign rd_sa = iss_srca_r;
  assign rd_sb = iss_srcb_r;
  logic [VLA_RW-1:0] iss_srca_r, iss_srcb_r;

  assign last    = ({1'b0, base} + LW'(LANES)) >= len_r;
  assign len_eff = (iss_len > LW'(MAXVL)) ? LW'(MAXVL) : iss_len;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_en[l] = busy && (({1'b0, base} + LW'(l)) < len_r);
  end

  function automatic logic in_flight(input logic [VLA_RW-1:0] r);
    return (busy && r == dst_r) || (t1.vld && r == t1.dst) ||
           (t2.vld && r == t2.dst);
  endfunction

  assign hazard    = in_flight(iss_dst) || in_flight(iss_srca) ||
                     in_flight(iss_srcb);
  assign iss_ready = (!busy || last) && !hazard;
  assign accept    = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      base <= '0;
      t1   <= '0;
      t2   <= '0;
    end else begin
      t1 <= '{vld: busy, last: last, dst: dst_r};
      t2 <= t1;
      if (accept) begin
        busy <= 1'b1;
        base <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      base <= base + IW'(LANES);
      end
    end
    if (accept) begin
      dst_r      <= iss_dst;
      iss_srca_r <= iss_srca;
      iss_srcb_r <= iss_srcb;
      len_r      <= len_eff;
    end
  end

  p_no_accept_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |-> !iss_ready)
    else $error("ready raised mid-instruction");

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !t1.vld && !t2.vld) |-> iss_ready)
    else $error("idle block not ready");
endmodule

// File: rtl/vla_rf.sv
module vla_rf
  import vla_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int MAXVL = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int AW   = VLA_RW + IW
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          wb_en,
  input  logic [LANES-1:0][IW-1:0]  wb_idx,
  input  logic [LANES-1:0][EW-1:0]  wb_data,
  input  logic [VLA_RW-1:0]         wb_dst,
  input  logic                      tp_we,
  input  logic [VLA_RW-1:0]         tp_wreg,
  input  logic [IW-1:0]             tp_widx,
  input  logic [EW-1:0]             tp_wdata,
  input  logic [VLA_RW-1:0]         rd_sa,
  input  logic [VLA_RW-1:0]         rd_sb,
  input  logic [IW-1:0]             base,
  output logic [LANES-1:0][EW-1:0]  opa,
  output logic [LANES-1:0][EW-1:0]  opb,
  input  logic [VLA_RW-1:0]         tp_rreg,
  input  logic [IW-1:0]             tp_ridx,
  output logic [EW-1:0]             tp_rdata
);
  logic [EW-1:0] mem [VLA_NREG*MAXVL];

  always_ff @(posedge clk) begin
    if (tp_we) mem[{tp_wreg, tp_widx}] <= tp_wdata;
    for (int l = 0; l < LANES; l++)
      if (wb_en[l]) mem[{wb_dst, wb_idx[l]}] <= wb_data[l];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    logic [IW-1:0] ix;
    assign ix     = base + IW'(l);
    assign opa[l] = mem[AW'({rd_sa, ix})];
    assign opb[l] = mem[AW'({rd_sb, ix})];
  end

  assign tp_rdata = mem[{tp_rreg, tp_ridx}];
endmodule

// File: rtl/vec_add_lanes.sv
module vec_add_lanes
  import vla_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int MAXVL = 16,
  localparam int IW   = $clog2(MAXVL),
  localparam int LW   = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [VLA_RW-1:0] iss_dst,
  input  logic [VLA_RW-1:0] iss_srca,
  input  logic [VLA_RW-1:0] iss_srcb,
  input  logic [LW-1:0]     iss_len,
  input  logic              tp_wr_en,
  input  logic [VLA_RW-1:0] tp_wr_reg,
  input  logic [IW-1:0]     tp_wr_idx,
  input  logic [EW-1:0]     tp_wr_data,
  input  logic [VLA_RW-1:0] tp_rd_reg,
  input  logic [IW-1:0]     tp_rd_idx,
  output logic [EW-1:0]     tp_rd_data,
  output logic              done,
  output logic [VLA_RW-1:0] done_dst
);
  logic [VLA_RW-1:0]        rd_sa, rd_sb;
  logic [IW-1:0]            base;
  logic [LANES-1:0]         lane_en, wb_en;
  logic [LANES-1:0][IW-1:0] wb_idx;
  logic [LANES-1:0][EW-1:0] wb_data, opa, opb;
  vla_tag_t                 t2;

  vla_seq #(.LANES(LANES), .MAXVL(MAXVL)) u_seq (
    .clk, .rst_n, .iss_valid, .iss_ready, .iss_dst, .iss_srca, .iss_srcb,
    .iss_len, .rd_sa, .rd_sb, .base, .lane_en, .t2
  );

  vla_rf #(.LANES(LANES), .EW(EW), .MAXVL(MAXVL)) u_rf (
    .clk, .wb_en, .wb_idx, .wb_data, .wb_dst(t2.dst),
    .tp_we(tp_wr_en), .tp_wreg(tp_wr_reg), .tp_widx(tp_wr_idx),
    .tp_wdata(tp_wr_data), .rd_sa, .rd_sb, .base, .opa, .opb,
    .tp_rreg(tp_rd_reg), .tp_ridx(tp_rd_idx), .tp_rdata(tp_rd_data)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vla_lane #(.EW(EW), .IW(IW), .LANES(LANES), .LANE(l)) u_lane (
      .clk, .rst_n, .in_en(lane_en[l]), .in_idx(base + IW'(l)),
      .in_a(opa[l]), .in_b(opb[l]),
      .wb_en(wb_en[l]), .wb_idx(wb_idx[l]), .wb_data(wb_data[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= t2.vld && t2.last;
    done_dst <= t2.dst;
  end

  p_wb_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_en) |-> t2.vld)
    else $error("lane write outside a live group");

  p_stall_hazard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && t2.vld) |->
      (iss_dst != t2.dst && iss_srca != t2.dst && iss_srcb != t2.dst))
    else $error("accepted over a pending write");
endmodule

// File: tb/test_vec_add_lanes.sv
`timescale 1ns/1ps
module test_vec_add_lanes;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iss_valid = 1'b0, iss_ready;
  logic [2:0]  iss_dst = '0, iss_srca = '0, iss_srcb = '0;
  logic [4:0]  iss_len = '0;
  logic        tp_wr_en = 1'b0;
  logic [2:0]  tp_wr_reg = '0, tp_rd_reg = '0;
  logic [3:0]  tp_wr_idx = '0, tp_rd_idx = '0;
  logic [31:0] tp_wr_data = '0, tp_rd_data;
  logic        done;
  logic [2:0]  done_dst;

  int checks = 0, errors = 0, cyc = 0, dn_cnt = 0;
  bit finished = 0;
  int dn_cyc [64];
  logic [2:0] dn_dst [64];
  logic [31:0] m [8][16];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && done) begin
    dn_cyc[dn_cnt % 64] = cyc;
    dn_dst[dn_cnt % 64] = done_dst;
    dn_cnt++;
  end

  vec_add_lanes i_vec_add_lanes (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int groups(input int len);
    int n = (len > 16) ? 16 : len;
    return (n == 0) ? 1 : (n + 3) / 4;
  endfunction

  task automatic send(input int d, a, b, len, output int acc);
    iss_dst = 3'(d); iss_srca = 3'(a); iss_srcb = 3'(b); iss_len = 5'(len);
    iss_valid = 1'b1;
    while (!iss_ready) @(negedge clk);
    @(posedge clk); #1 acc = cyc;
    for (int i = 0; i < ((len > 16) ? 16 : len); i++) m[d][i] = m[a][i] + m[b][i];
    @(negedge clk); iss_valid = 1'b0;
  endtask

  task automatic wait_dn(input int target);
    while (dn_cnt < target) @(negedge clk);
  endtask

  task automatic check_reg(input int r, input int n, input string req);
    for (int i = 0; i < 16; i++) begin
      tp_rd_reg = 3'(r); tp_rd_idx = 4'(i); #1;
      chk(tp_rd_data === m[r][i], (i < n) ? req : "R4",
          $sformatf("reg%0d[%0d]", r, i), tp_rd_data, m[r][i]);
    end
  endtask

  task automatic run_one(input int d, a, b, len);
    int acc, tgt, n;
    n = (len > 16) ? 16 : len;
    tgt = dn_cnt + 1;
    send(d, a, b, len, acc);
    wait_dn(tgt);
    // R3: done G+2 cycles after acceptance, carrying the destination
    chk(dn_cyc[(tgt-1)%64] - acc == groups(len) + 2, (len == 0 || len > 16) ? "R5" : "R3",
        $sformatf("done latency len=%0d", len), 32'(dn_cyc[(tgt-1)%64] - acc), 32'(groups(len) + 2));
    chk(dn_dst[(tgt-1)%64] == 3'(d), "R3", "done_dst", 32'(dn_dst[(tgt-1)%64]), 32'(d));
    check_reg(d, n, (len > 16) ? "R5" : "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a1, a2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(iss_ready === 1'b1, "R9", "ready after reset", 32'(iss_ready), 1);
    chk(done === 1'b0, "R9", "done after reset", 32'(done), 0);

    // R8: preload every element, wide values so sums wrap
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        m[r][i] = (32'(r + 1) * 32'h2357_9BDF) ^ (32'(i) * 32'h0F1E_2D3C) + 32'hF000_0000;
        tp_wr_en = 1'b1; tp_wr_reg = 3'(r); tp_wr_idx = 4'(i); tp_wr_data = m[r][i];
      end
    @(negedge clk); tp_wr_en = 1'b0;
    for (int r = 0; r < 8; r++) check_reg(r, 16, "R8");

    // R1 R2 R4 R5: sweep every length including 0 and beyond 16
    for (int len = 0; len < 18; len++)
      run_one(5 + len % 3, len % 5, (len + 2) % 5, len);
    run_one(3, 3, 4, 9);   // destination equals a source

    // R6: independent back-to-back, no gap
    send(5, 0, 1, 8, a1);
    send(6, 2, 3, 8, a2);
    chk(a2 - a1 == 2, "R6", "back-to-back accept gap", 32'(a2 - a1), 2);
    wait_dn(dn_cnt + 2);
    check_reg(5, 8, "R6"); check_reg(6, 8, "R6");

    // R7: read-after-write stall
    send(5, 0, 1, 16, a1);
    send(7, 5, 2, 4, a2);
    chk(a2 - a1 == 7, "R7", "RAW stall gap", 32'(a2 - a1), 7);
    wait_dn(dn_cnt + 1); repeat (8) @(negedge clk);
    check_reg(5, 16, "R7"); check_reg(7, 4, "R7");

    // R7: write-after-write stall and final contents
    send(6, 0, 1, 16, a1);
    send(6, 2, 3, 4, a2);
    chk(a2 - a1 == 7, "R7", "WAW stall gap", 32'(a2 - a1), 7);
    repeat (12) @(negedge clk);
    check_reg(6, 16, "R7");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule